// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and main memory. The processor pushes each store into the buffer in the same cycle as it updates the cache, then carries on without waiting for memory. The buffer drains its stores to memory one at a time, in the order they arrived, over a single request/acknowledge memory port.

Read requests from cache misses do not queue behind the stores. A read is first matched against every buffered store, including one that memory is still writing. If the youngest store to the same word wrote every byte, its data is returned at once and memory is not read. If the youngest store wrote only some bytes, the read waits until no matching store is left in the buffer. If nothing matches, the read goes to memory ahead of every store that is still waiting. A memory transfer that has begun is never interrupted.

Reads and stores are word-granular. Byte-enable bit i qualifies data byte i, and an all-ones mask is a full-word store. The depth must be a power of two, at least 2.

Top module: `wbuf_bypass`

## Requirements
- R1: While reset is applied and right after it, `st_stall_o`, `mem_req_o` and `rd_rsp_o` are low.
- R2: The buffer accepts a store on a clock edge where `st_valid_i` is high and `st_stall_o` is low. `st_stall_o` is high exactly while the buffer holds DEPTH stores. A store presented while `st_stall_o` is high is dropped and never reaches memory.
- R3: Buffered stores reach memory as write transfers (`mem_we_o` = 1) strictly in arrival order. Each transfer carries the store's address, data and byte mask unchanged.
- R4: Once `mem_req_o` rises, it stays high and `mem_we_o`, `mem_addr_o`, `mem_wdata_o` and `mem_be_o` stay constant until the edge that samples `mem_ack_i` high.
- R5: Suppose the memory port is idle, a read is pending that matches no buffered store, and stores are waiting. The next transfer is then the read (`mem_we_o` = 0), not the oldest store.
- R6: For a read sent to memory, `rd_rsp_o` is high for exactly one cycle, starting at the edge that samples `mem_ack_i`. In that cycle `rd_data_o` carries the value of `mem_rdata_i` at that edge.
- R7: Suppose the youngest buffered store to the read address has an all-ones byte mask. `rd_rsp_o` then rises at the first edge that samples the request, `rd_data_o` is that store's data, and no read transfer is issued. Older stores to the same address, partial or not, have no effect.
- R8: Suppose the youngest buffered store to the read address has a byte mask that is not all ones. The read then waits until every store to that address has been written to memory, and only then reads memory.
- R9: A store accepted into an empty buffer with the memory port idle starts its write transfer one edge after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Processor store present |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte mask |
| st_stall_o | output | 1 | Buffer full; store is not taken |
| rd_req_i | input | 1 | Read request, held until the response |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_rsp_o | output | 1 | One-cycle read response strobe |
| rd_data_o | output | DATA_W | Read response data |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr_o | output | ADDR_W | Transfer word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_be_o | output | DATA_W/8 | Write byte mask |
| mem_ack_i | input | 1 | Transfer complete, one cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with the acknowledge |

## Verification
The assertions assume the following. A requester holds `rd_req_i` and `rd_addr_i` steady until it sees `rd_rsp_o`, then drops the request before the next edge. Memory raises `mem_ack_i` for a single cycle, and only while `mem_req_o` is high. The bench meets both assumptions: it changes every input on the falling edge, holds each read until the response appears, and uses a memory model that counts a programmable latency during an active request and then acknowledges once. Under those conditions the checks on ordering, bypass priority and forwarding look only at the transfers that appear on the memory port.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
module wbuf_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic [ADDR_W-1:0]             push_addr_i,
  input  logic [DATA_W-1:0]             push_data_i,
  input  logic [BE_W-1:0]               push_be_i,
  input  logic                          pop_i,
  output logic                          full_o,
  output logic                          empty_o,
  output logic [ADDR_W-1:0]             head_addr_o,
  output logic [DATA_W-1:0]             head_data_o,
  output logic [BE_W-1:0]               head_be_o,
  // slots listed oldest (0) to youngest
  output logic [DEPTH-1:0]              age_vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  age_addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  age_data_o,
  output logic [DEPTH-1:0][BE_W-1:0]    age_be_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
      be_q[wr_ptr_q]   <= push_be_i;
    end
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign head_be_o   = be_q[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PW-1:0] idx;
    assign idx           = rd_ptr_q + PW'(g);
    assign age_vld_o[g]  = (cnt_q > CW'(g));
    assign age_addr_o[g] = addr_q[idx];
    assign age_data_o[g] = data_q[idx];
    assign age_be_o[g]   = be_q[idx];
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wbuf_match.sv
`timescale 1ns/1ps
module wbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [DEPTH-1:0]              age_vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  age_addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  age_data_i,
  input  logic [DEPTH-1:0][BE_W-1:0]    age_be_i,
  output logic                          hit_o,
  output logic                          whole_o,
  output logic [DATA_W-1:0]             data_o
);
  // scan oldest to youngest; last match wins
  always_comb begin
    hit_o   = 1'b0;
    whole_o = 1'b0;
    data_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_vld_i[i] && (age_addr_i[i] == rd_addr_i)) begin
        hit_o   = 1'b1;
        whole_o = &age_be_i[i];
        data_o  = age_data_i[i];
      end
    end
  end
endmodule

// File: rtl/wbuf_mem_port.sv
`timescale 1ns/1ps
module wbuf_mem_port
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_go_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_avail_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [BE_W-1:0]   head_be_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic              rd_start_o,
  output logic              rd_done_o,
  output logic              wr_done_o
);
  logic              busy_q;
  mem_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic              grant_rd, grant_wr;

  assign grant_rd = !busy_q && rd_go_i;
  assign grant_wr = !busy_q && !rd_go_i && wr_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (grant_rd) begin
      busy_q <= 1'b1;
      op_q   <= OP_READ;
      addr_q <= rd_addr_i;
      data_q <= '0;
      be_q   <= '0;
    end else if (grant_wr) begin
      busy_q <= 1'b1;
      op_q   <= OP_WRITE;
      addr_q <= head_addr_i;
      data_q <= head_data_i;
      be_q   <= head_be_i;
    end else if (busy_q && mem_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_we_o    = (op_q == OP_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_be_o    = be_q;
  assign rd_start_o  = grant_rd;
  assign rd_done_o   = busy_q && mem_ack_i && (op_q == OP_READ);
  assign wr_done_o   = busy_q && mem_ack_i && (op_q == OP_WRITE);

  assert_req_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                   && $stable(mem_wdata_o) && $stable(mem_be_o)));
  assert_read_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && rd_go_i && wr_avail_i) |=> (mem_req_o && !mem_we_o));
endmodule

// File: rtl/wbuf_bypass.sv
`timescale 1ns/1ps
module wbuf_bypass #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   st_valid_i,
  input  logic [ADDR_W-1:0]      st_addr_i,
  input  logic [DATA_W-1:0]      st_data_i,
  input  logic [DATA_W/8-1:0]    st_be_i,
  output logic                   st_stall_o,
  input  logic                   rd_req_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic                   rd_rsp_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  output logic [DATA_W/8-1:0]    mem_be_o,
  input  logic                   mem_ack_i,
  input  logic [DATA_W-1:0]      mem_rdata_i
);
  localparam int BE_W = DATA_W / 8;

  logic                          full, empty, push, pop;
  logic [ADDR_W-1:0]             head_addr;
  logic [DATA_W-1:0]             head_data;
  logic [BE_W-1:0]               head_be;
  logic [DEPTH-1:0]              age_vld;
  logic [DEPTH-1:0][ADDR_W-1:0]  age_addr;
  logic [DEPTH-1:0][DATA_W-1:0]  age_data;
  logic [DEPTH-1:0][BE_W-1:0]    age_be;
  logic                          m_hit, m_whole;
  logic [DATA_W-1:0]             m_data;
  logic                          rd_mem_q, rsp_q;
  logic [DATA_W-1:0]             rsp_data_q;
  logic                          rd_pend, fwd, rd_go, rd_start, rd_done;

  assign push       = st_valid_i && !full;
  assign st_stall_o = full;

  wbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(st_addr_i), .push_data_i(st_data_i), .push_be_i(st_be_i),
    .pop_i(pop), .full_o(full), .empty_o(empty),
    .head_addr_o(head_addr), .head_data_o(head_data), .head_be_o(head_be),
    .age_vld_o(age_vld), .age_addr_o(age_addr), .age_data_o(age_data), .age_be_o(age_be)
  );

  wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) i_match (
    .rd_addr_i, .age_vld_i(age_vld), .age_addr_i(age_addr), .age_data_i(age_data),
    .age_be_i(age_be), .hit_o(m_hit), .whole_o(m_whole), .data_o(m_data)
  );

  // read not yet served and not yet at memory
  assign rd_pend = rd_req_i && !rd_mem_q && !rsp_q;
  assign fwd     = rd_pend && m_hit && m_whole;
  assign rd_go   = rd_pend && !m_hit;

  wbuf_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) i_mem_port (
    .clk_i, .rst_ni,
    .rd_go_i(rd_go), .rd_addr_i,
    .wr_avail_i(!empty), .head_addr_i(head_addr), .head_data_i(head_data), .head_be_i(head_be),
    .mem_ack_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o,
    .rd_start_o(rd_start), .rd_done_o(rd_done), .wr_done_o(pop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mem_q   <= 1'b0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      if (rd_start)     rd_mem_q <= 1'b1;
      else if (rd_done) rd_mem_q <= 1'b0;
      rsp_q <= fwd || rd_done;
      if (fwd)          rsp_data_q <= m_data;
      else if (rd_done) rsp_data_q <= mem_rdata_i;
    end
  end

  assign rd_rsp_o  = rsp_q;
  assign rd_data_o = rsp_data_q;

  assert_rsp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsp_o |=> !rd_rsp_o);
  assert_partial_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_mem_q && m_hit && !m_whole) |-> !rd_start);
  assert_forward_no_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_mem_q && !rsp_q && m_hit && m_whole) |=> !(mem_req_o && !mem_we_o && !$past(mem_req_o)));
endmodule

// File: tb/test_wbuf_bypass.sv
`timescale 1ns/1ps
module test_wbuf_bypass;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0;
  logic [15:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic [3:0]  st_be_i = '0;
  logic        st_stall_o;
  logic        rd_req_i = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic        rd_rsp_o;
  logic [31:0] rd_data_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0, lat = 2, wcnt = 0, log_n = 0;
  logic        lg_we   [32];
  logic [15:0] lg_addr [32];
  logic [31:0] lg_data [32];
  logic [3:0]  lg_be   [32];

  always #2 clk = ~clk;

  wbuf_bypass i_wbuf_bypass (
    .clk_i(clk), .rst_ni, .st_valid_i, .st_addr_i, .st_data_i, .st_be_i, .st_stall_o,
    .rd_req_i, .rd_addr_i, .rd_rsp_o, .rd_data_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o, .mem_ack_i, .mem_rdata_i
  );

  function automatic logic [31:0] rdval(input logic [15:0] a);
    return {16'hC0DE, a};
  endfunction

  // memory model: acknowledge after lat cycles of request, log every transfer
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      wcnt++;
      if (wcnt >= lat) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = rdval(mem_addr_o);
        if (log_n < 32) begin
          lg_we[log_n]   = mem_we_o;
          lg_addr[log_n] = mem_addr_o;
          lg_data[log_n] = mem_wdata_o;
          lg_be[log_n]   = mem_be_o;
        end
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    while (st_stall_o) @(negedge clk);
    st_valid_i = 1'b1; st_addr_i = a; st_data_i = d; st_be_i = be;
    @(negedge clk);
    st_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d, output int cyc);
    rd_addr_i = a; rd_req_i = 1'b1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rd_rsp_o && cyc < 300);
    d = rd_data_o;
    rd_req_i = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic chk_wr(input int i, input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input string req);
    chk(lg_we[i] == 1'b1, req, 64'(lg_we[i]), 64'd1);
    chk(lg_addr[i] == a, req, 64'(lg_addr[i]), 64'(a));
    chk(lg_data[i] == d, req, 64'(lg_data[i]), 64'(d));
    chk(lg_be[i] == be, req, 64'(lg_be[i]), 64'(be));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(st_stall_o == 1'b0, "R1 stall in reset", 64'(st_stall_o), 64'd0);
    chk(mem_req_o == 1'b0, "R1 req in reset", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rd_rsp_o == 1'b0, "R1 rsp after reset", 64'(rd_rsp_o), 64'd0);
    chk(mem_req_o == 1'b0, "R1 req after reset", 64'(mem_req_o), 64'd0);
  endtask

  task automatic t_single();
    lat = 2; log_n = 0;
    push(16'h0010, 32'h1111_2222, 4'hF);
    chk(mem_req_o == 1'b0, "R9 no request at accept", 64'(mem_req_o), 64'd0);
    @(negedge clk);
    chk(mem_req_o && mem_we_o, "R9 write starts next edge", 64'({mem_req_o, mem_we_o}), 64'd3);
    settle();
    chk(log_n == 1, "R3 one transfer", 64'(log_n), 64'd1);
    chk_wr(0, 16'h0010, 32'h1111_2222, 4'hF, "R3 single store");
  endtask

  task automatic t_full();
    lat = 4; log_n = 0;
    for (int i = 0; i < 4; i++) push(16'h0020 + 16'(i), 32'hA000_0000 + 32'(i), 4'(i + 1));
    chk(st_stall_o == 1'b1, "R2 stall when full", 64'(st_stall_o), 64'd1);
    st_valid_i = 1'b1; st_addr_i = 16'h002F; st_data_i = 32'hDEAD_BEEF; st_be_i = 4'hF;
    @(negedge clk);
    st_valid_i = 1'b0;
    settle();
    chk(st_stall_o == 1'b0, "R2 stall clears", 64'(st_stall_o), 64'd0);
    chk(log_n == 4, "R2 dropped store not written", 64'(log_n), 64'd4);
    for (int i = 0; i < 4; i++) chk_wr(i, 16'h0020 + 16'(i), 32'hA000_0000 + 32'(i), 4'(i + 1), "R3 order");
  endtask

  task automatic t_bypass();
    logic [31:0] d; int cyc;
    lat = 3; log_n = 0;
    push(16'h0030, 32'h3000_0000, 4'hF);
    push(16'h0031, 32'h3000_0001, 4'hF);
    push(16'h0032, 32'h3000_0002, 4'hF);
    do_read(16'h0040, d, cyc);
    chk(d == rdval(16'h0040), "R6 read data", 64'(d), 64'(rdval(16'h0040)));
    @(negedge clk);
    chk(rd_rsp_o == 1'b0, "R6 single-cycle response", 64'(rd_rsp_o), 64'd0);
    settle();
    chk(log_n == 4, "R5 transfer count", 64'(log_n), 64'd4);
    chk_wr(0, 16'h0030, 32'h3000_0000, 4'hF, "R4 in-flight store kept");
    chk(lg_we[1] == 1'b0 && lg_addr[1] == 16'h0040, "R5 read overtakes", 64'({lg_we[1], lg_addr[1]}), 64'h0040);
    chk_wr(2, 16'h0031, 32'h3000_0001, 4'hF, "R5 stores after read");
    chk_wr(3, 16'h0032, 32'h3000_0002, 4'hF, "R5 stores after read");
  endtask

  task automatic t_forward();
    logic [31:0] d; int cyc;
    lat = 10; log_n = 0;
    push(16'h0050, 32'h5555_0001, 4'hF);
    push(16'h0050, 32'h5555_0002, 4'hF);
    push(16'h0051, 32'h5555_0003, 4'hF);
    do_read(16'h0050, d, cyc);
    chk(d == 32'h5555_0002, "R7 youngest data", 64'(d), 64'h5555_0002);
    chk(cyc == 1, "R7 forward latency", 64'(cyc), 64'd1);
    settle();
    push(16'h0060, 32'h6666_0001, 4'h3);
    push(16'h0060, 32'h6666_0002, 4'hF);
    do_read(16'h0060, d, cyc);
    chk(d == 32'h6666_0002, "R7 older partial ignored", 64'(d), 64'h6666_0002);
    chk(cyc == 1, "R7 forward latency 2", 64'(cyc), 64'd1);
    settle();
    chk(log_n == 5, "R7 no memory read", 64'(log_n), 64'd5);
    for (int i = 0; i < 5; i++) chk(lg_we[i] == 1'b1, "R7 only writes", 64'(lg_we[i]), 64'd1);
  endtask

  task automatic t_partial();
    logic [31:0] d; int cyc, n_at;
    lat = 3; log_n = 0;
    push(16'h0070, 32'h7777_0001, 4'hF);
    push(16'h0070, 32'h7777_0002, 4'hC);
    do_read(16'h0070, d, cyc);
    n_at = log_n;
    chk(d == rdval(16'h0070), "R8 data from memory", 64'(d), 64'(rdval(16'h0070)));
    chk(cyc > 1, "R8 read waited", 64'(cyc), 64'd2);
    chk(n_at == 3, "R8 writes before read", 64'(n_at), 64'd3);
    chk(lg_we[2] == 1'b0 && lg_addr[2] == 16'h0070, "R8 read last", 64'({lg_we[2], lg_addr[2]}), 64'h0070);
    chk_wr(1, 16'h0070, 32'h7777_0002, 4'hC, "R8 partial store written");
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_full();
    t_bypass();
    t_forward();
    t_partial();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule